// File: doc/BRIEF.md
# Instruction Address Match Interrupt Unit

This unit watches the address of the instruction that the core is about to execute and compares it with four programmable match addresses. Each match address has its own enable. When an enabled address equals the fetch address, the unit raises an interrupt request before that instruction runs. It also reports which source hit and the program-counter value that the core should push. The request has no input for the global interrupt-enable flag or the priority level, so neither can mask it.

The pushed value is deliberately not the true return address. It is the match address plus a small offset. A one-bit opcode-class input from the decoder selects that offset. When the core runs its external bus in 8-bit mode, matches on external-area addresses are suppressed. Software configures the unit through a synchronous write port. A combinational read port returns every match and enable register.

Top module: `fetch_watch_irq`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0 and every configuration address (0 to 7) reads back 0.
- R2: Configuration addresses 0 to 3 hold the four 20-bit match addresses. Address 4 holds the enables of sources 0 and 1 in bits 0 and 1. Address 5 holds the enables of sources 2 and 3 in bits 0 and 1. All other bits of addresses 4 and 5 read 0. Addresses 6 and 7 read 0 and ignore writes.
- R3: A cycle with `fetch_valid` high whose `fetch_addr` equals the address of an enabled source sets `irq_req` at the next clock edge.
- R4: A source whose enable bit is 0 never raises a request, even when its address matches.
- R5: `irq_pc` is the fetch address plus 2 when `fetch_long` is 1, and plus 1 when it is 0. The sum wraps modulo 2^20.
- R6: A fetch with both `bus_narrow` and `ext_area` high never raises a request. Either flag on its own does not suppress the match.
- R7: When several enabled sources hit in the same cycle, `irq_src` reports the lowest index.
- R8: Once raised, `irq_req`, `irq_src` and `irq_pc` hold their values until a cycle with `irq_ack` high. The request is 0 after that edge. Fetches that arrive while a request is pending, or in the acknowledge cycle, are ignored.
- R9: A fetch with `fetch_valid` low never raises a request.
- R10: Because reset clears every enable, a fetch at address 0 right after reset raises no request, even though all match addresses are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select, used for both write and read |
| cfg_wdata | input | 20 | Configuration write data |
| cfg_rdata | output | 20 | Combinational readback of the selected register |
| fetch_valid | input | 1 | A new instruction is about to execute |
| fetch_addr | input | 20 | Start address of that instruction |
| fetch_long | input | 1 | Opcode class: 1 selects offset 2, 0 selects offset 1 |
| bus_narrow | input | 1 | External bus is configured 8 bits wide |
| ext_area | input | 1 | Fetch address lies in the external area |
| irq_ack | input | 1 | Core accepted the request; clears it |
| irq_req | output | 1 | Registered interrupt request |
| irq_src | output | 2 | Index of the source that hit |
| irq_pc | output | 20 | Program-counter value to push |

## Verification
A corrupted enable or match register shows up in one of two ways. Either a fetch that should hit stays silent, or a spurious request appears one clock after the fetch. The readback port exposes the same corruption right away. A stuck or mis-cleared hold register shows a request that survives an acknowledge, or a source index or pushed value that drifts while the request is pending. That drift is visible on the next cycle. Random fetches drawn from a small address pool make hits, multi-source collisions and pending-time fetches frequent. Each one is compared cycle by cycle against a reference model.

// File: rtl/fw_pkg.sv
package fw_pkg;

  // Opcode class supplied by the decoder
  typedef enum logic {
    OPC_SHORT = 1'b0,
    OPC_LONG  = 1'b1
  } opc_class_e;

  // Offset added to the matched address to form the pushed value
  function automatic int unsigned push_offset(opc_class_e cls);
    return (cls == OPC_LONG) ? 32'd2 : 32'd1;
  endfunction

endpackage

// File: rtl/fw_match_regs.sv
module fw_match_regs #(
  parameter int ADDR_W  = 20,
  parameter int NUM_SRC = 4,
  parameter int CFG_AW  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [CFG_AW-1:0]              cfg_addr,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic [ADDR_W-1:0]              cfg_rdata,
  output logic [NUM_SRC-1:0][ADDR_W-1:0] match_addr,
  output logic [NUM_SRC-1:0]             src_en
);

  localparam int HALF = NUM_SRC / 2;
  localparam int HI_N = NUM_SRC - HALF;
  localparam logic [CFG_AW-1:0] CTL_LO = CFG_AW'(NUM_SRC);
  localparam logic [CFG_AW-1:0] CTL_HI = CFG_AW'(NUM_SRC + 1);

  // Match address registers, one per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mreg
    always_ff @(posedge clk) begin
      if (rst) begin
        match_addr[i] <= '0;
      end else if (cfg_we && cfg_addr == CFG_AW'(i)) begin
        match_addr[i] <= cfg_wdata;
      end
    end
  end

  // Enable bits split across two control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      src_en <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CTL_LO) src_en[HALF-1:0]       <= cfg_wdata[HALF-1:0];
      if (cfg_addr == CTL_HI) src_en[NUM_SRC-1:HALF] <= cfg_wdata[HI_N-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CTL_LO) begin
      cfg_rdata[HALF-1:0] = src_en[HALF-1:0];
    end else if (cfg_addr == CTL_HI) begin
      cfg_rdata[HI_N-1:0] = src_en[NUM_SRC-1:HALF];
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cfg_addr == CFG_AW'(i)) cfg_rdata = match_addr[i];
      end
    end
  end

endmodule

// File: rtl/fw_addr_cmp.sv
module fw_addr_cmp #(
  parameter int ADDR_W  = 20,
  parameter int NUM_SRC = 4
) (
  input  logic                           fetch_valid,
  input  logic [ADDR_W-1:0]              fetch_addr,
  input  logic                           bus_narrow,
  input  logic                           ext_area,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] match_addr,
  input  logic [NUM_SRC-1:0]             src_en,
  output logic [NUM_SRC-1:0]             hit
);

  logic qualify;

  // External area is unreachable for matching on a narrow bus
  assign qualify = fetch_valid && !(bus_narrow && ext_area);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign hit[i] = qualify && src_en[i] && (match_addr[i] == fetch_addr);
  end

endmodule

// File: rtl/fw_lowest_pick.sv
module fw_lowest_pick #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] hit,
  output logic               any_hit,
  output logic [SEL_W-1:0]   hit_idx
);

  always_comb begin
    any_hit = |hit;
    hit_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = SEL_W'(i);
    end
  end

endmodule

// File: rtl/fw_req_hold.sv
module fw_req_hold
  import fw_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_hit,
  input  logic [SEL_W-1:0]  hit_idx,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_long,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [SEL_W-1:0]  irq_src,
  output logic [ADDR_W-1:0] irq_pc
);

  opc_class_e  cls;
  logic [ADDR_W-1:0] pc_next;

  assign cls     = fetch_long ? OPC_LONG : OPC_SHORT;
  assign pc_next = fetch_addr + ADDR_W'(push_offset(cls));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_src <= '0;
      irq_pc  <= '0;
    end else if (irq_ack) begin
      irq_req <= 1'b0;
    end else if (!irq_req && any_hit) begin
      irq_req <= 1'b1;
      irq_src <= hit_idx;
      irq_pc  <= pc_next;
    end
  end

endmodule

// File: rtl/fetch_watch_irq.sv
module fetch_watch_irq #(
  parameter  int ADDR_W  = 20,
  parameter  int NUM_SRC = 4,
  localparam int SEL_W   = $clog2(NUM_SRC),
  localparam int CFG_AW  = $clog2(NUM_SRC + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_long,
  input  logic              bus_narrow,
  input  logic              ext_area,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [SEL_W-1:0]  irq_src,
  output logic [ADDR_W-1:0] irq_pc
);

  logic [NUM_SRC-1:0][ADDR_W-1:0] match_addr;
  logic [NUM_SRC-1:0]             en_vec;
  logic [NUM_SRC-1:0]             hit;
  logic                           any_hit;
  logic [SEL_W-1:0]               hit_idx;

  fw_match_regs #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .CFG_AW(CFG_AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .match_addr (match_addr),
    .src_en     (en_vec)
  );

  fw_addr_cmp #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_cmp (
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .bus_narrow  (bus_narrow),
    .ext_area    (ext_area),
    .match_addr  (match_addr),
    .src_en      (en_vec),
    .hit         (hit)
  );

  fw_lowest_pick #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_pick (
    .hit     (hit),
    .any_hit (any_hit),
    .hit_idx (hit_idx)
  );

  fw_req_hold #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .any_hit    (any_hit),
    .hit_idx    (hit_idx),
    .fetch_addr (fetch_addr),
    .fetch_long (fetch_long),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .irq_src    (irq_src),
    .irq_pc     (irq_pc)
  );

endmodule

// File: rtl/fw_checks.sv
module fw_checks #(
  parameter  int ADDR_W  = 20,
  parameter  int NUM_SRC = 4,
  localparam int SEL_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_valid,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               fetch_long,
  input logic               bus_narrow,
  input logic               ext_area,
  input logic               irq_ack,
  input logic               irq_req,
  input logic [SEL_W-1:0]   irq_src,
  input logic [ADDR_W-1:0]  irq_pc,
  input logic [NUM_SRC-1:0] en_vec
);

  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_vec;
  end

  // R3 and R9: a new request follows a valid fetch
  a_r3_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(fetch_valid));

  // R4: the reporting source was enabled when the fetch was seen
  a_r4_src_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> en_q[irq_src]);

  // R5: pushed value is the fetch address plus the class offset
  a_r5_pc_offset: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |->
      irq_pc == ADDR_W'($past(fetch_addr) + ($past(fetch_long) ? 2 : 1)));

  // R6: no request from the external area on a narrow bus
  a_r6_narrow_ext: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(bus_narrow && ext_area));

  // R8: pending request holds its fields
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_src) && $stable(irq_pc)));

  // R8: acknowledge clears the request
  a_r8_ack_clear: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req);

endmodule

bind fetch_watch_irq fw_checks #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_fw_checks (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .fetch_long  (fetch_long),
  .bus_narrow  (bus_narrow),
  .ext_area    (ext_area),
  .irq_ack     (irq_ack),
  .irq_req     (irq_req),
  .irq_src     (irq_src),
  .irq_pc      (irq_pc),
  .en_vec      (en_vec)
);

// File: tb/test_fetch_watch_irq.sv
`timescale 1ns/1ps
module test_fetch_watch_irq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_rdata;
  logic        fetch_valid = 1'b0;
  logic [19:0] fetch_addr = '0;
  logic        fetch_long = 1'b0;
  logic        bus_narrow = 1'b0;
  logic        ext_area = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [1:0]  irq_src;
  logic [19:0] irq_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [19:0] m_addr [4];
  logic [3:0]  m_en;
  logic        e_req;
  logic [1:0]  e_src;
  logic [19:0] e_pc;

  always #2.5 clk = ~clk;

  fetch_watch_irq i_fetch_watch_irq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_long(fetch_long),
    .bus_narrow(bus_narrow), .ext_area(ext_area), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_src(irq_src), .irq_pc(irq_pc)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] rb_exp(input logic [2:0] a);
    if (a < 3'd4)  return m_addr[a[1:0]];
    if (a == 3'd4) return {18'd0, m_en[1:0]};
    if (a == 3'd5) return {18'd0, m_en[3:2]};
    return 20'd0;
  endfunction

  task automatic cyc(input logic we, input logic [2:0] a, input logic [19:0] d,
                     input logic v, input logic [19:0] fa, input logic lg,
                     input logic nar, input logic ext, input logic ack,
                     input string tag);
    bit found;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    fetch_valid = v; fetch_addr = fa; fetch_long = lg;
    bus_narrow = nar; ext_area = ext; irq_ack = ack;
    found = 0;
    if (ack) begin
      e_req = 1'b0;
    end else if (!e_req && v && !(nar && ext)) begin
      for (int i = 0; i < 4; i++) begin
        if (!found && m_en[i] && m_addr[i] == fa) begin
          found = 1;
          e_req = 1'b1;
          e_src = 2'(i);
          e_pc  = fa + (lg ? 20'd2 : 20'd1);
        end
      end
    end
    if (we) begin
      if (a < 3'd4)       m_addr[a[1:0]] = d;
      else if (a == 3'd4) m_en[1:0] = d[1:0];
      else if (a == 3'd5) m_en[3:2] = d[1:0];
    end
    @(posedge clk); #1;
    chk(irq_req === e_req, {tag, " req"}, 32'(irq_req), 32'(e_req));
    if (e_req) begin
      chk(irq_src === e_src, {tag, " src"}, 32'(irq_src), 32'(e_src));
      chk(irq_pc === e_pc, {tag, " pc"}, 32'(irq_pc), 32'(e_pc));
    end
    chk(cfg_rdata === rb_exp(a), {tag, " R2 readback"}, 32'(cfg_rdata), 32'(rb_exp(a)));
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d, input string tag);
    cyc(1'b1, a, d, 1'b0, 20'd0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic fetch(input logic [19:0] fa, input logic lg, input logic nar,
                       input logic ext, input string tag);
    cyc(1'b0, 3'd0, 20'd0, 1'b1, fa, lg, nar, ext, 1'b0, tag);
  endtask

  task automatic ack(input string tag);
    cyc(1'b0, 3'd0, 20'd0, 1'b0, 20'd0, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] pool [4];
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_addr[i] = '0;
    m_en = '0; e_req = 0; e_src = '0; e_pc = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(irq_req === 1'b0, "R1 req after reset", 32'(irq_req), 0);
    for (int a = 0; a < 8; a++) begin
      cfg_addr = 3'(a); #0.5;
      chk(cfg_rdata === 20'd0, "R1 readback after reset", 32'(cfg_rdata), 0);
    end
    fetch(20'd0, 1'b0, 1'b0, 1'b0, "R10");
    chk(irq_req === 1'b0, "R10 no request", 32'(irq_req), 0);

    wr(3'd0, 20'h12345, "R2"); wr(3'd4, 20'hFFFFF, "R2");
    wr(3'd5, 20'hFFFFE, "R2"); wr(3'd6, 20'hABCDE, "R2");
    wr(3'd7, 20'h55555, "R2"); wr(3'd5, 20'h0, "R2"); wr(3'd4, 20'h0, "R2");

    wr(3'd0, 20'h00400, "R3"); wr(3'd4, 20'h1, "R3");
    fetch(20'h00400, 1'b0, 1'b0, 1'b0, "R3");
    chk(irq_pc === 20'h00401, "R5 short offset", 32'(irq_pc), 32'h401);
    fetch(20'h00400, 1'b1, 1'b0, 1'b0, "R8 pending fetch ignored");
    chk(irq_pc === 20'h00401, "R8 pc held", 32'(irq_pc), 32'h401);
    ack("R8 ack");
    fetch(20'h00400, 1'b1, 1'b0, 1'b0, "R5");
    chk(irq_pc === 20'h00402, "R5 long offset", 32'(irq_pc), 32'h402);
    ack("R8");
    wr(3'd1, 20'hFFFFF, "R5"); wr(3'd4, 20'h3, "R5");
    fetch(20'hFFFFF, 1'b1, 1'b0, 1'b0, "R5 wrap");
    chk(irq_pc === 20'h00001, "R5 wrap value", 32'(irq_pc), 1);
    ack("R8");
    wr(3'd2, 20'h00777, "R4");
    fetch(20'h00777, 1'b0, 1'b0, 1'b0, "R4 disabled");
    chk(irq_req === 1'b0, "R4 no request", 32'(irq_req), 0);
    fetch(20'h00400, 1'b0, 1'b1, 1'b1, "R6 suppressed");
    chk(irq_req === 1'b0, "R6 no request", 32'(irq_req), 0);
    fetch(20'h00400, 1'b0, 1'b1, 1'b0, "R6 narrow only"); ack("R8");
    fetch(20'h00400, 1'b0, 1'b0, 1'b1, "R6 ext only"); ack("R8");
    wr(3'd2, 20'h00400, "R7"); wr(3'd3, 20'h00400, "R7");
    wr(3'd5, 20'h3, "R7"); wr(3'd4, 20'h0, "R7");
    fetch(20'h00400, 1'b0, 1'b0, 1'b0, "R7");
    chk(irq_src === 2'd2, "R7 lowest of 2,3", 32'(irq_src), 2);
    ack("R8"); wr(3'd4, 20'h1, "R7");
    fetch(20'h00400, 1'b0, 1'b0, 1'b0, "R7");
    chk(irq_src === 2'd0, "R7 lowest of 0,2,3", 32'(irq_src), 0);
    ack("R8");
    cyc(1'b0, 3'd0, 20'd0, 1'b0, 20'h00400, 1'b0, 1'b0, 1'b0, 1'b0, "R9 invalid");
    chk(irq_req === 1'b0, "R9 no request", 32'(irq_req), 0);

    pool[0] = 20'h00400; pool[1] = 20'h00010; pool[2] = 20'hFFFFF; pool[3] = 20'h00031;
    for (int n = 0; n < 3000; n++) begin
      logic       we;
      logic [2:0] a;
      logic [19:0] d;
      we = ($urandom % 5) == 0;
      a  = 3'($urandom % 8);
      d  = (a < 3'd4) ? pool[$urandom % 4] : 20'($urandom);
      cyc(we, a, d, 1'($urandom % 4 != 0), pool[$urandom % 4], 1'($urandom),
          1'($urandom % 3 == 0), 1'($urandom % 3 == 0),
          e_req && ($urandom % 3 == 0), "R3/R4/R6/R7/R8 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule